// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins behind a flat 32-bit register port. Each pin is independently a plain input, a driven output, or an interrupt source. Interrupt sources sense a high level, a low level, a rising edge, a falling edge, or both edges. Edge events are latched per pin until software clears them. Level conditions track the pin directly. All enabled, active status bits are ORed into one interrupt request.

Pin inputs pass through a two-flop synchroniser before any sensing. The input data register always shows the synchronised level, even on pins that are driving. The register port is a plain single-cycle write strobe with a combinational read: `bus_rdata` always reflects `bus_addr`. The block has no flow-controlled data interface, so it applies no back-pressure. Interrupt enables are split into two registers. One register can only turn enables off. The other can only turn them on. This lets two agents share the enable state without read-modify-write.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every readable register reads zero, `pin_oe` and `irq_out` are low, and a read of an unmapped offset (for example 0x2C) returns zero.
- R2: `pin_oe[i]` is 1 only when bit i of the mode register (0x00) is 0 and bit i of the direction register (0x04) is 1. `pin_out` equals the output data register (0x08).
- R3: The input register (0x0C) shows each pin's level after two clock synchronisation, on input and output pins alike.
- R4: A pin with mode bit 1 and edge-select bit (0x24) 0 is level-sensed. Its status bit (0x10) is 1 while the pin is at the active level: high when its polarity bit (0x20) is 0, low when it is 1. A write to the clear register (0x14) does not change it.
- R5: A pin with mode bit 1, edge-select bit 1 and both-edge bit (0x4C) 0 latches its status bit on a rising edge when polarity is 0, or on a falling edge when polarity is 1. The opposite transition does not set it, and the latch holds after the pin returns.
- R6: With mode, edge-select and both-edge bits all 1, either transition latches the status bit, whatever the polarity bit.
- R7: Writing 1 to bit i of the clear register (0x14) clears pin i's latched edge event, and writing 0 leaves it. A new edge arriving in the same cycle as the clear write wins, and the bit stays set.
- R8: A write to the mask register (0x18) keeps enables written 1 and disables those written 0. A write of 1 to the mask-clear register (0x1C) enables that pin, and 0 leaves it. Reading 0x18 returns the enables.
- R9: `irq_out` is high exactly when some status bit and its enable bit are both 1.
- R10: A pin whose mode bit is 0 shows status 0. Leaving edge interrupt mode discards any latched event, so re-entering it starts clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Drive values |
| pin_oe | output | NUM_PINS | Per-pin drive enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a fresh edge on an already-pending pin. If the design gave the clear priority, the new event would be lost. To create this case, the bench toggles the pin on a falling clock edge and lets exactly two rising edges pass through the synchroniser. It then presents the clear write, so that the write is sampled on the very edge that latches the new event. The bench then expects the status bit to remain set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MODE   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_DIR    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_DOUT   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_DIN    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CLR    = 8'h14;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_POL    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_EDGE   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_BOTH   = 8'h4C;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [REG_DW-1:0]   wr_data,
  output logic [NUM_PINS-1:0] mode_irq,
  output logic [NUM_PINS-1:0] dir_out,
  output logic [NUM_PINS-1:0] dout,
  output logic [NUM_PINS-1:0] pol_low,
  output logic [NUM_PINS-1:0] edge_sel,
  output logic [NUM_PINS-1:0] both_sel,
  output logic [NUM_PINS-1:0] irq_en,
  output logic [NUM_PINS-1:0] clr_pulse
);
  logic [NUM_PINS-1:0] wd;
  assign wd = wr_data[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_irq <= '0;
      dir_out  <= '0;
      dout     <= '0;
      pol_low  <= '0;
      edge_sel <= '0;
      both_sel <= '0;
      irq_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_MODE:   mode_irq <= wd;
        OFS_DIR:    dir_out  <= wd;
        OFS_DOUT:   dout     <= wd;
        OFS_POL:    pol_low  <= wd;
        OFS_EDGE:   edge_sel <= wd;
        OFS_BOTH:   both_sel <= wd;
        OFS_MASK:   irq_en   <= irq_en & wd;
        OFS_UNMASK: irq_en   <= irq_en | wd;
        default: ;
      endcase
    end
  end

  assign clr_pulse = (wr_en && wr_addr == OFS_CLR) ? wd : '0;

  // R8: a zero written to the mask register leaves that enable off
  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_MASK) |=> ((irq_en & ~$past(wd)) == '0));
  // R8: a one written to mask-clear leaves that enable on
  assert_unmask_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_UNMASK) |=> ((irq_en & $past(wd)) == $past(wd)));
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense #(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] mode_irq,
  input  logic [NUM_PINS-1:0] pol_low,
  input  logic [NUM_PINS-1:0] edge_sel,
  input  logic [NUM_PINS-1:0] both_sel,
  input  logic [NUM_PINS-1:0] clr_pulse,
  output logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] status
);
  logic [NUM_PINS-1:0] stage [SYNC_STAGES];
  logic [NUM_PINS-1:0] prev;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] edge_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
      prev <= '0;
    end else begin
      stage[0] <= pin_raw;
      for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      prev <= stage[SYNC_STAGES-1];
    end
  end

  assign pin_sync = stage[SYNC_STAGES-1];
  assign edge_arm = mode_irq & edge_sel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall;
    assign rise   = pin_sync[i] & ~prev[i];
    assign fall   = ~pin_sync[i] & prev[i];
    assign hit[i] = both_sel[i] ? (rise | fall) : (pol_low[i] ? fall : rise);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend[i] <= 1'b0;
      else if (!edge_arm[i]) pend[i] <= 1'b0;
      else if (hit[i])       pend[i] <= 1'b1;
      else if (clr_pulse[i]) pend[i] <= 1'b0;
    end

    always_comb begin
      if (edge_arm[i])      status[i] = pend[i];
      else if (mode_irq[i]) status[i] = pin_sync[i] ^ pol_low[i];
      else                  status[i] = 1'b0;
    end
  end

  // R5: a latched event only appears after a detected transition
  assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(hit)) == '0));
  // R7: a clear with no competing edge empties the latch
  assert_clr_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & $past(clr_pulse & ~hit)) == '0));
  // R10: no latched event survives outside edge interrupt mode
  assert_pend_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(edge_arm)) == '0));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [REG_AW-1:0]   rd_addr,
  input  logic [NUM_PINS-1:0] mode_irq,
  input  logic [NUM_PINS-1:0] dir_out,
  input  logic [NUM_PINS-1:0] dout,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] status,
  input  logic [NUM_PINS-1:0] irq_en,
  input  logic [NUM_PINS-1:0] pol_low,
  input  logic [NUM_PINS-1:0] edge_sel,
  input  logic [NUM_PINS-1:0] both_sel,
  output logic [REG_DW-1:0]   rd_data
);
  function automatic logic [REG_DW-1:0] widen(input logic [NUM_PINS-1:0] v);
    logic [REG_DW-1:0] w;
    w = '0;
    w[NUM_PINS-1:0] = v;
    return w;
  endfunction

  always_comb begin
    case (rd_addr)
      OFS_MODE: rd_data = widen(mode_irq);
      OFS_DIR:  rd_data = widen(dir_out);
      OFS_DOUT: rd_data = widen(dout);
      OFS_DIN:  rd_data = widen(pin_sync);
      OFS_STAT: rd_data = widen(status);
      OFS_MASK: rd_data = widen(irq_en);
      OFS_POL:  rd_data = widen(pol_low);
      OFS_EDGE: rd_data = widen(edge_sel);
      OFS_BOTH: rd_data = widen(both_sel);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [REG_DW-1:0]   bus_wdata,
  output logic [REG_DW-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  logic [NUM_PINS-1:0] mode_irq, dir_out, dout, pol_low, edge_sel, both_sel;
  logic [NUM_PINS-1:0] irq_en, clr_pulse, pin_sync, status;

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .mode_irq(mode_irq), .dir_out(dir_out), .dout(dout),
    .pol_low(pol_low), .edge_sel(edge_sel), .both_sel(both_sel),
    .irq_en(irq_en), .clr_pulse(clr_pulse)
  );

  gpio_pin_sense #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
    .mode_irq(mode_irq), .pol_low(pol_low), .edge_sel(edge_sel),
    .both_sel(both_sel), .clr_pulse(clr_pulse),
    .pin_sync(pin_sync), .status(status)
  );

  gpio_read_mux #(.NUM_PINS(NUM_PINS)) u_rd (
    .rd_addr(bus_addr), .mode_irq(mode_irq), .dir_out(dir_out),
    .dout(dout), .pin_sync(pin_sync), .status(status), .irq_en(irq_en),
    .pol_low(pol_low), .edge_sel(edge_sel), .both_sel(both_sel),
    .rd_data(bus_rdata)
  );

  assign pin_oe  = dir_out & ~mode_irq;
  assign pin_out = dout;
  assign irq_out = |(status & irq_en);

  // R2: an interrupt-mode pin never drives
  assert_oe_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & mode_irq) == '0));
  // R9: a request needs at least one enable
  assert_irq_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_en != '0));
  // R10: status never shows on plain I/O pins
  assert_stat_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mode_irq) == '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int N = 32;
  localparam logic [7:0] A_MODE = 8'h00, A_DIR = 8'h04, A_DOUT = 8'h08,
    A_DIN = 8'h0C, A_STAT = 8'h10, A_CLR = 8'h14, A_MASK = 8'h18,
    A_UNMASK = 8'h1C, A_POL = 8'h20, A_EDGE = 8'h24, A_BOTH = 8'h4C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 mode", A_MODE, 0);
    rd_check("R1 dir", A_DIR, 0);
    rd_check("R1 mask", A_MASK, 0);
    rd_check("R1 stat", A_STAT, 0);
    rd_check("R1 unmapped", 8'h2C, 0);
    check("R1 oe", pin_oe, 0);
    check("R1 irq", {31'd0, irq_out}, 0);
  endtask

  task automatic t_output;
    wr(A_DIR, 32'h0000_00F0);
    wr(A_DOUT, 32'h0000_00A5);
    #1;
    check("R2 oe", pin_oe, 32'h0000_00F0);
    check("R2 out", pin_out, 32'h0000_00A5);
    wr(A_MODE, 32'h0000_0010);
    #1;
    check("R2 oe irq-mode", pin_oe, 32'h0000_00E0);
    wr(A_MODE, 0);
  endtask

  task automatic t_input;
    set_pins(32'h1234_5678);
    rd_check("R3 din incl outputs", A_DIN, 32'h1234_5678);
    set_pins(0);
    rd_check("R3 din zero", A_DIN, 0);
    wr(A_DIR, 0);
  endtask

  task automatic t_level;
    wr(A_MODE, 32'h1);
    wr(A_UNMASK, 32'h1);
    rd_check("R4 idle", A_STAT, 0);
    check("R9 idle irq", {31'd0, irq_out}, 0);
    set_pins(32'h1);
    rd_check("R4 high active", A_STAT, 32'h1);
    check("R9 irq level", {31'd0, irq_out}, 1);
    wr(A_CLR, 32'h1);
    rd_check("R4 clear ignored", A_STAT, 32'h1);
    wr(A_POL, 32'h1);
    rd_check("R4 low pol inactive", A_STAT, 0);
    set_pins(0);
    rd_check("R4 low pol active", A_STAT, 32'h1);
    wr(A_MASK, 32'hFFFF_FFFE);
    #1;
    check("R9 masked irq", {31'd0, irq_out}, 0);
    rd_check("R8 mask read", A_MASK, 0);
    wr(A_MODE, 0);
    rd_check("R10 plain pin status", A_STAT, 0);
    wr(A_POL, 0);
  endtask

  task automatic t_edge;
    wr(A_MODE, 32'h2);
    wr(A_EDGE, 32'h2);
    wr(A_CLR, 32'h2);
    wr(A_UNMASK, 32'h2);
    set_pins(32'h2);
    rd_check("R5 rising latched", A_STAT, 32'h2);
    check("R9 irq edge", {31'd0, irq_out}, 1);
    set_pins(0);
    rd_check("R5 latch holds", A_STAT, 32'h2);
    wr(A_CLR, 32'hFFFF_FFFD);
    rd_check("R7 zero no effect", A_STAT, 32'h2);
    wr(A_CLR, 32'h2);
    rd_check("R7 clear", A_STAT, 0);
    wr(A_POL, 32'h2);
    set_pins(32'h2);
    rd_check("R5 rise ignored falling pol", A_STAT, 0);
    set_pins(0);
    rd_check("R5 falling latched", A_STAT, 32'h2);
    wr(A_CLR, 32'h2);
    wr(A_POL, 0);
  endtask

  task automatic t_both;
    wr(A_MODE, 32'h4);
    wr(A_EDGE, 32'h4);
    wr(A_BOTH, 32'h4);
    wr(A_POL, 32'h4);
    wr(A_CLR, 32'h4);
    wr(A_UNMASK, 32'h4);
    set_pins(32'h4);
    rd_check("R6 rise", A_STAT, 32'h4);
    wr(A_CLR, 32'h4);
    rd_check("R6 cleared", A_STAT, 0);
    set_pins(0);
    rd_check("R6 fall", A_STAT, 32'h4);
    // R7: clear write lands on the edge that latches a new event
    @(negedge clk);
    pin_in = 32'h4;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h4;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_check("R7 edge beats clear", A_STAT, 32'h4);
  endtask

  task automatic t_mask;
    rd_check("R8 enables before", A_MASK, 32'h6);
    wr(A_MASK, 32'hFFFF_FFFB);
    rd_check("R8 disable by zero", A_MASK, 32'h2);
    wr(A_UNMASK, 0);
    rd_check("R8 unmask zero no effect", A_MASK, 32'h2);
    wr(A_UNMASK, 32'h10);
    rd_check("R8 enable by one", A_MASK, 32'h12);
  endtask

  task automatic t_leave;
    rd_check("R10 pending before leave", A_STAT, 32'h4);
    wr(A_MODE, 0);
    rd_check("R10 left mode", A_STAT, 0);
    wr(A_MODE, 32'h4);
    rd_check("R10 reentry clean", A_STAT, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_leave();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule